// File: doc/BRIEF.md
# Single-Pulse Byte Programming Sequencer

This block sits in a host-side device programmer and writes an image into a one-time or UV-erasable code memory, one byte at a time. Software or a loader issues a start command with a base address and a byte count, then streams the image bytes over a valid/ready channel. For each byte the sequencer presents the address and the data. After a setup interval it asks the analog stage to raise the programming supply. It fires a single timed programming strobe, drops the supply, waits for the supply to settle, and moves on to the next address.

The mode control lines that put the target into programming mode are driven once at the start of the job and held unchanged across all bytes. They are not re-applied per byte. Each byte gets exactly one strobe, and no retry loop exists. Every interval is a clock count fixed by a parameter: the mode settle, the data setup, the supply settle after each supply edge, and the strobe width. An abort input drops the supply request and the strobe on the next clock and returns the sequencer to idle.

Top module: `byte_prog_seq`

## Requirements
- R1: After reset the sequencer is idle: `data_ready_o`, `vpp_en_o`, `prog_strobe_o`, `busy_o` and `done_o` are 0, and `mode_o` equals `MODE_IDLE`.
- R2: A start in idle with a non-zero count drives `mode_o` to `MODE_PROG` for `MODE_CYC` cycles before the first address phase. `MODE_PROG` then stays constant through every byte until the last supply-lower interval ends.
- R3: `data_ready_o` is 1 only in the address phase. A byte is taken on a clock edge where `data_valid_i` and `data_ready_o` are both 1, and each address phase takes exactly one byte.
- R4: After a byte is taken, `data_o` shows it and `addr_o` stays unchanged for `SETUP_CYC` cycles before `vpp_en_o` rises.
- R5: `vpp_en_o` stays high for `SETTLE_CYC + PULSE_CYC` cycles. `prog_strobe_o` is high for exactly the last `PULSE_CYC` of those cycles.
- R6: Each programmed byte receives exactly one strobe pulse.
- R7: After `vpp_en_o` falls, the sequencer waits `SETTLE_CYC` cycles before the next address phase or completion. `addr_o` and `data_o` do not change while `vpp_en_o` is high.
- R8: `addr_o` takes `base_addr_i` at start and increases by one for each following byte, wrapping modulo 2^`ADDR_W`.
- R9: `done_o` is a single-cycle pulse in the cycle after the last byte's supply-lower interval. `busy_o` is 1 from the cycle after start until `done_o` falls.
- R10: A start with `byte_cnt_i` equal to 0 gives a `done_o` pulse on the next cycle with no supply request and no strobe.
- R11: `abort_i` returns the sequencer to idle on the next cycle, with `vpp_en_o`, `prog_strobe_o` and `busy_o` low and no `done_o`. A start that arrives together with abort is ignored.
- R12: `start_i` has no effect while the sequencer is busy, including the completion cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin a programming job (acted on only when idle) |
| abort_i | input | 1 | Stop the job and return to idle |
| base_addr_i | input | ADDR_W | First target address, captured at start |
| byte_cnt_i | input | CNT_W | Number of bytes to program, captured at start |
| data_valid_i | input | 1 | Image byte available |
| data_i | input | DATA_W | Image byte |
| data_ready_o | output | 1 | Sequencer takes a byte this cycle if valid |
| mode_o | output | MODE_W | Target mode control lines |
| addr_o | output | ADDR_W | Target address bus |
| data_o | output | DATA_W | Target data bus |
| vpp_en_o | output | 1 | Request for the programming supply level |
| prog_strobe_o | output | 1 | Programming strobe, active high |
| busy_o | output | 1 | A job is in progress |
| done_o | output | 1 | One-cycle job completion pulse |

## Verification
The bench feeds bytes both back-to-back and with long gaps. A sequencer that raised the supply before data arrived, or that took two bytes in one address phase, would shift every later address and strobe. A base address near the top of the space checks the wrap; a design that saturated or carried into a wider register would show a wrong address. A zero-count job must finish without ever asserting the supply, and a design that underflowed its counter would program thousands of bytes. An abort during the strobe and a start issued mid-job test that the supply drops at once and that the running job is not restarted at a new address.

// File: rtl/byte_prog_seq_pkg.sv
// Package: shared state encoding for the byte programming sequencer.
// Assumes: used by the FSM only; other modules see decoded controls.
package byte_prog_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,  // waiting for start
        ST_MODE  = 3'd1,  // mode lines applied, settling
        ST_ADDR  = 3'd2,  // address on bus, waiting for a byte
        ST_DATA  = 3'd3,  // address and data setup before supply rise
        ST_RISE  = 3'd4,  // supply requested, settling
        ST_PULSE = 3'd5,  // programming strobe active
        ST_FALL  = 3'd6,  // supply released, settling
        ST_FIN   = 3'd7   // completion pulse
    } bps_state_e;

endpackage

// File: rtl/byte_prog_seq_timer.sv
// Module: interval timer. Loads a count and decrements to zero.
// Assumes: the loaded value is the interval length minus one, so an
// interval of N cycles spans N clock edges before zero_o ends it.
module byte_prog_seq_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [TW-1:0] val_i,
    output logic          zero_o
);

    logic [TW-1:0] cnt_q;

    // Load on request, otherwise count down and hold at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/byte_prog_seq_dpath.sv
// Module: address, remaining-count and data registers.
// Assumes: start, accept and step are mutually exclusive strobes
// generated by the FSM; the address wraps at the bus width.
module byte_prog_seq_dpath #(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 8,
    parameter int CNT_W  = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              accept_i,
    input  logic              step_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic [DATA_W-1:0] din_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] data_o,
    output logic              last_o,
    output logic              count_zero_o
);

    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  rem_q;
    logic [DATA_W-1:0] data_q;

    // Track target address and bytes still to program.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            rem_q  <= '0;
        end else if (start_i) begin
            addr_q <= base_i;
            rem_q  <= count_i;
        end else if (step_i) begin
            addr_q <= addr_q + 1'b1;
            rem_q  <= rem_q - 1'b1;
        end
    end

    // Hold the byte taken in the address phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (accept_i) begin
            data_q <= din_i;
        end
    end

    assign addr_o       = addr_q;
    assign data_o       = data_q;
    assign last_o       = (rem_q == CNT_W'(1));
    assign count_zero_o = (count_i == '0);

endmodule

// File: rtl/byte_prog_seq_fsm.sv
// Module: phase sequencer. Walks each byte through address, setup,
// supply rise, strobe and supply fall, and decodes the pin controls.
// Assumes: every interval parameter is at least 1 (smaller values are
// raised to 1); abort overrides every other input.
module byte_prog_seq_fsm
    import byte_prog_seq_pkg::*;
#(
    parameter int TW         = 8,
    parameter int MODE_CYC   = 8,
    parameter int SETUP_CYC  = 4,
    parameter int SETTLE_CYC = 50,
    parameter int PULSE_CYC  = 100
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          abort_i,
    input  logic          data_valid_i,
    input  logic          count_zero_i,
    input  logic          last_i,
    input  logic          tmr_zero_i,
    output logic          tmr_load_o,
    output logic [TW-1:0] tmr_val_o,
    output logic          dp_start_o,
    output logic          dp_accept_o,
    output logic          dp_step_o,
    output logic          ready_o,
    output logic          mode_on_o,
    output logic          vpp_o,
    output logic          strobe_o,
    output logic          busy_o,
    output logic          done_o
);

    localparam int MC_E = (MODE_CYC   < 1) ? 1 : MODE_CYC;
    localparam int SU_E = (SETUP_CYC  < 1) ? 1 : SETUP_CYC;
    localparam int ST_E = (SETTLE_CYC < 1) ? 1 : SETTLE_CYC;
    localparam int PW_E = (PULSE_CYC  < 1) ? 1 : PULSE_CYC;
    localparam logic [TW-1:0] LD_MODE   = TW'(MC_E - 1);
    localparam logic [TW-1:0] LD_SETUP  = TW'(SU_E - 1);
    localparam logic [TW-1:0] LD_SETTLE = TW'(ST_E - 1);
    localparam logic [TW-1:0] LD_PULSE  = TW'(PW_E - 1);

    bps_state_e state_q, state_d;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next phase and datapath strobes; abort wins over everything.
    always_comb begin
        state_d     = state_q;
        dp_start_o  = 1'b0;
        dp_accept_o = 1'b0;
        dp_step_o   = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    dp_start_o = 1'b1;
                    state_d    = count_zero_i ? ST_FIN : ST_MODE;
                end
            end
            ST_MODE:  if (tmr_zero_i) state_d = ST_ADDR;
            ST_ADDR: begin
                if (data_valid_i) begin
                    dp_accept_o = 1'b1;
                    state_d     = ST_DATA;
                end
            end
            ST_DATA:  if (tmr_zero_i) state_d = ST_RISE;
            ST_RISE:  if (tmr_zero_i) state_d = ST_PULSE;
            ST_PULSE: if (tmr_zero_i) state_d = ST_FALL;
            ST_FALL: begin
                if (tmr_zero_i) begin
                    if (last_i) begin
                        state_d = ST_FIN;
                    end else begin
                        dp_step_o = 1'b1;
                        state_d   = ST_ADDR;
                    end
                end
            end
            ST_FIN:   state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
        if (abort_i) begin
            state_d     = ST_IDLE;
            dp_start_o  = 1'b0;
            dp_accept_o = 1'b0;
            dp_step_o   = 1'b0;
        end
    end

    // Interval length for the phase being entered.
    always_comb begin
        tmr_load_o = (state_d != state_q);
        case (state_d)
            ST_MODE:  tmr_val_o = LD_MODE;
            ST_DATA:  tmr_val_o = LD_SETUP;
            ST_RISE:  tmr_val_o = LD_SETTLE;
            ST_PULSE: tmr_val_o = LD_PULSE;
            ST_FALL:  tmr_val_o = LD_SETTLE;
            default:  tmr_val_o = '0;
        endcase
    end

    // Pin controls decoded from the current phase.
    always_comb begin
        ready_o   = (state_q == ST_ADDR);
        mode_on_o = (state_q != ST_IDLE) && (state_q != ST_FIN);
        vpp_o     = (state_q == ST_RISE) || (state_q == ST_PULSE);
        strobe_o  = (state_q == ST_PULSE);
        busy_o    = (state_q != ST_IDLE);
        done_o    = (state_q == ST_FIN);
    end

endmodule

// File: rtl/byte_prog_seq.sv
// Module: top of the single-pulse byte programming sequencer.
// Assumes: the analog stage follows vpp_en_o; intervals are in clocks
// of clk; mode lines read MODE_IDLE whenever no job is running.
module byte_prog_seq #(
    parameter int                 ADDR_W     = 13,
    parameter int                 DATA_W     = 8,
    parameter int                 CNT_W      = 14,
    parameter int                 MODE_W     = 4,
    parameter logic [MODE_W-1:0]  MODE_PROG  = MODE_W'(4'hD),
    parameter logic [MODE_W-1:0]  MODE_IDLE  = '0,
    parameter int                 MODE_CYC   = 8,
    parameter int                 SETUP_CYC  = 4,
    parameter int                 SETTLE_CYC = 50,
    parameter int                 PULSE_CYC  = 25000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              abort_i,
    input  logic [ADDR_W-1:0] base_addr_i,
    input  logic [CNT_W-1:0]  byte_cnt_i,
    input  logic              data_valid_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              data_ready_o,
    output logic [MODE_W-1:0] mode_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] data_o,
    output logic              vpp_en_o,
    output logic              prog_strobe_o,
    output logic              busy_o,
    output logic              done_o
);

    localparam int MAX_AB  = (MODE_CYC > SETUP_CYC) ? MODE_CYC : SETUP_CYC;
    localparam int MAX_CD  = (SETTLE_CYC > PULSE_CYC) ? SETTLE_CYC : PULSE_CYC;
    localparam int MAX_CYC = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
    localparam int TW      = $clog2(MAX_CYC + 1) + 1;

    logic          tmr_load, tmr_zero;
    logic [TW-1:0] tmr_val;
    logic          dp_start, dp_accept, dp_step;
    logic          last_byte, count_zero, mode_on;

    byte_prog_seq_fsm #(
        .TW(TW), .MODE_CYC(MODE_CYC), .SETUP_CYC(SETUP_CYC),
        .SETTLE_CYC(SETTLE_CYC), .PULSE_CYC(PULSE_CYC)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .start_i(start_i), .abort_i(abort_i), .data_valid_i(data_valid_i),
        .count_zero_i(count_zero), .last_i(last_byte), .tmr_zero_i(tmr_zero),
        .tmr_load_o(tmr_load), .tmr_val_o(tmr_val),
        .dp_start_o(dp_start), .dp_accept_o(dp_accept), .dp_step_o(dp_step),
        .ready_o(data_ready_o), .mode_on_o(mode_on), .vpp_o(vpp_en_o),
        .strobe_o(prog_strobe_o), .busy_o(busy_o), .done_o(done_o)
    );

    byte_prog_seq_timer #(.TW(TW)) u_tmr (
        .clk(clk), .rst_n(rst_n),
        .load_i(tmr_load), .val_i(tmr_val), .zero_o(tmr_zero)
    );

    byte_prog_seq_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_dp (
        .clk(clk), .rst_n(rst_n),
        .start_i(dp_start), .accept_i(dp_accept), .step_i(dp_step),
        .base_i(base_addr_i), .count_i(byte_cnt_i), .din_i(data_i),
        .addr_o(addr_o), .data_o(data_o),
        .last_o(last_byte), .count_zero_o(count_zero)
    );

    // Mode lines: programming code for the whole job, idle code otherwise.
    assign mode_o = mode_on ? MODE_PROG : MODE_IDLE;

endmodule

// File: rtl/byte_prog_seq_checker.sv
// Module: protocol checker for the sequencer pins, bound to the top.
// Assumes: observes ports only; all properties are off during reset.
module byte_prog_seq_checker #(
    parameter int                ADDR_W    = 13,
    parameter int                DATA_W    = 8,
    parameter int                MODE_W    = 4,
    parameter logic [MODE_W-1:0] MODE_PROG = MODE_W'(4'hD)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              abort_i,
    input logic              data_ready_o,
    input logic [MODE_W-1:0] mode_o,
    input logic [ADDR_W-1:0] addr_o,
    input logic [DATA_W-1:0] data_o,
    input logic              vpp_en_o,
    input logic              prog_strobe_o,
    input logic              busy_o,
    input logic              done_o
);

    // Strobe only while the supply is requested.
    assert_strobe_under_vpp_R5: assert property (@(posedge clk) disable iff (!rst_n)
        prog_strobe_o |-> vpp_en_o);

    // No byte is taken while the supply is up.
    assert_ready_supply_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        data_ready_o |-> (!vpp_en_o && !prog_strobe_o));

    // Buses frozen while the supply is high.
    assert_bus_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (vpp_en_o && $past(vpp_en_o)) |-> ($stable(addr_o) && $stable(data_o)));

    // Buses already settled when the supply rises.
    assert_setup_before_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vpp_en_o) |-> ($stable(addr_o) && $stable(data_o)));

    // Mode lines carry the programming code whenever the supply is up.
    assert_mode_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (vpp_en_o || data_ready_o) |-> (mode_o == MODE_PROG));

    // Completion is a single-cycle pulse.
    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // Abort clears supply, strobe and busy on the next cycle.
    assert_abort_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
        abort_i |=> (!vpp_en_o && !prog_strobe_o && !busy_o && !done_o));

endmodule

bind byte_prog_seq byte_prog_seq_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MODE_W(MODE_W), .MODE_PROG(MODE_PROG)
) u_chk (
    .clk(clk), .rst_n(rst_n), .abort_i(abort_i),
    .data_ready_o(data_ready_o), .mode_o(mode_o), .addr_o(addr_o),
    .data_o(data_o), .vpp_en_o(vpp_en_o), .prog_strobe_o(prog_strobe_o),
    .busy_o(busy_o), .done_o(done_o)
);

// File: tb/byte_prog_seq_tb.sv
// Bench: behavioural per-cycle model compared with the sequencer pins.
module byte_prog_seq_tb;

    localparam int AW = 6;
    localparam int DW = 8;
    localparam int CW = 8;
    localparam int MW = 4;
    localparam logic [MW-1:0] MP = 4'hD;
    localparam logic [MW-1:0] MI = 4'h0;
    localparam int MC = 3;
    localparam int SU = 2;
    localparam int ST = 3;
    localparam int PW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, abort = 1'b0, dv = 1'b0;
    logic [AW-1:0] base = '0;
    logic [CW-1:0] cnt = '0;
    logic [DW-1:0] din = '0;

    logic ready, vpp, strobe, busy, done;
    logic [MW-1:0] mode;
    logic [AW-1:0] addr;
    logic [DW-1:0] dout;

    int n_cmp = 0;
    int n_bad = 0;
    bit cmp_en = 1'b0;
    bit finished = 1'b0;
    logic acc = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    byte_prog_seq #(
        .ADDR_W(AW), .DATA_W(DW), .CNT_W(CW), .MODE_W(MW),
        .MODE_PROG(MP), .MODE_IDLE(MI), .MODE_CYC(MC), .SETUP_CYC(SU),
        .SETTLE_CYC(ST), .PULSE_CYC(PW)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .abort_i(abort),
        .base_addr_i(base), .byte_cnt_i(cnt), .data_valid_i(dv), .data_i(din),
        .data_ready_o(ready), .mode_o(mode), .addr_o(addr), .data_o(dout),
        .vpp_en_o(vpp), .prog_strobe_o(strobe), .busy_o(busy), .done_o(done)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model: phase 0 idle,1 mode,2 address,3 setup,4 rise,5 strobe,6 fall,7 done.
    int m_phase = 0;
    int m_left = 0;
    int m_rem = 0;
    logic [AW-1:0] m_addr = '0;
    logic [DW-1:0] m_data = '0;

    always @(posedge clk) begin
        acc <= dv && ready;
        if (!rst_n) begin
            m_phase = 0; m_left = 0; m_rem = 0; m_addr = '0; m_data = '0;
        end else if (abort) begin
            m_phase = 0;
        end else begin
            case (m_phase)
                0: if (start) begin
                       m_addr = base; m_rem = cnt;
                       if (cnt == 0) m_phase = 7;
                       else begin m_phase = 1; m_left = MC; end
                   end
                2: if (dv) begin m_data = din; m_phase = 3; m_left = SU; end
                7: m_phase = 0;
                default: begin
                    m_left--;
                    if (m_left == 0) begin
                        case (m_phase)
                            1: m_phase = 2;
                            3: begin m_phase = 4; m_left = ST; end
                            4: begin m_phase = 5; m_left = PW; end
                            5: begin m_phase = 6; m_left = ST; end
                            default: begin
                                if (m_rem == 1) m_phase = 7;
                                else begin m_rem--; m_addr = m_addr + 1'b1; m_phase = 2; end
                            end
                        endcase
                    end
                end
            endcase
        end
    end

    // Compare every pin against the model away from the active edge.
    always @(negedge clk) begin
        if (rst_n && cmp_en) begin
            check("R3 ready", int'(ready), int'(m_phase == 2));
            check("R2 mode", int'(mode), int'((m_phase >= 1 && m_phase <= 6) ? MP : MI));
            check("R8 addr", int'(addr), int'(m_addr));
            check("R4 data", int'(dout), int'(m_data));
            check("R5 vpp", int'(vpp), int'(m_phase == 4 || m_phase == 5));
            check("R6 strobe", int'(strobe), int'(m_phase == 5));
            check("R12 busy", int'(busy), int'(m_phase != 0));
            check("R9 done", int'(done), int'(m_phase == 7));
        end
    end

    // Run one job; gap = idle cycles before each byte is offered.
    task automatic run_job(input logic [AW-1:0] b, input int n, input int gap,
                           input bit abort_on_strobe, input bit start_mid,
                           output int rises, output bit saw_done);
        int idx = 0;
        int wt = gap;
        bit prev = 1'b0;
        rises = 0; saw_done = 1'b0;
        @(negedge clk); start = 1'b1; base = b; cnt = CW'(n);
        @(negedge clk); start = 1'b0;
        for (int cyc = 0; cyc < 2000; cyc++) begin
            if (done) begin saw_done = 1'b1; break; end
            if (strobe && !prev) rises++;
            prev = strobe;
            if (acc) begin dv = 1'b0; idx++; wt = gap; end
            if (!dv && idx < n) begin
                if (wt == 0) begin dv = 1'b1; din = DW'((int'(b) + idx * 37) ^ 8'h5A); end
                else wt--;
            end
            start = (start_mid && cyc == 6);
            if (start) base = b + 6'd20;
            if (abort_on_strobe && strobe) begin
                abort = 1'b1;
                @(negedge clk); abort = 1'b0; dv = 1'b0;
                check("R11 vpp after abort", int'(vpp), 0);
                check("R11 strobe after abort", int'(strobe), 0);
                check("R11 busy after abort", int'(busy), 0);
                break;
            end
            @(negedge clk);
        end
        start = 1'b0; dv = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        int r;
        bit d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 ready", int'(ready), 0);
        check("R1 vpp", int'(vpp), 0);
        check("R1 strobe", int'(strobe), 0);
        check("R1 busy", int'(busy), 0);
        check("R1 done", int'(done), 0);
        check("R1 mode", int'(mode), int'(MI));
        cmp_en = 1'b1;

        run_job(6'h10, 3, 0, 1'b0, 1'b0, r, d);      // R6 back-to-back bytes
        check("R6 pulses", r, 3); check("R9 done seen", int'(d), 1);
        run_job(6'h05, 3, 5, 1'b0, 1'b0, r, d);      // R3 slow data source
        check("R6 pulses slow", r, 3); check("R9 done slow", int'(d), 1);
        run_job(6'h3E, 4, 1, 1'b0, 1'b0, r, d);      // R8 wrap past top
        check("R8 wrap pulses", r, 4); check("R8 wrap done", int'(d), 1);
        run_job(6'h20, 0, 0, 1'b0, 1'b0, r, d);      // R10 empty job
        check("R10 no pulse", r, 0); check("R10 done", int'(d), 1);
        run_job(6'h01, 2, 0, 1'b0, 1'b1, r, d);      // R12 start mid-job
        check("R12 pulses", r, 2); check("R12 done", int'(d), 1);
        run_job(6'h08, 3, 0, 1'b1, 1'b0, r, d);      // R11 abort in strobe
        check("R11 no done", int'(d), 0);

        // R11 start together with abort in idle is ignored
        @(negedge clk); start = 1'b1; abort = 1'b1; cnt = 8'd2;
        @(negedge clk); start = 1'b0; abort = 1'b0;
        check("R11 start+abort busy", int'(busy), 0);
        repeat (3) @(negedge clk);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule